// File: doc/BRIEF.md
# Programmable Sub-Pixel Edge Timing Generator

This block runs from a fast tick clock and splits every pixel period into 48 ticks. It produces a horizontal clock `hClk` whose rising and falling edges can each be placed on any of the 48 ticks, together with `hClkN`, which is always the exact inverse of `hClk`. A tick-0 marker, `pixStart`, lets surrounding logic align to the period.

Edge positions are given as 6-bit quadrant codes. The upper two bits select a quarter of the period and the lower four bits select one of twelve steps inside it. A code whose step field is out of range is rejected. New settings take effect only at a period boundary, so a period is never cut short or glitched.

A pixel sample stream enters once per period. It passes through a fixed pipeline of whole periods and is then retimed onto `dataOut` at a programmable tick of the output period.

Top module: `subpix_edge_gen`

## Requirements
- R1: The tick counter counts 0 to 47 and wraps, so a period is 48 clocks long. `pixStart` is high exactly during tick 0 of every period.
- R2: An edge code holds a quadrant q in bits [5:4] and a step s in bits [3:0], with s from 0 to 11. It selects tick location 12*q + s, so every location from 0 to 47 can be reached.
- R3: An edge code with a step field of 12 to 15, or a phase value of 48 to 63, is rejected, and the setting it would replace stays in force. `codeErr` is high for the whole period whose boundary rejected at least one value, and low otherwise.
- R4: With distinct rise and fall locations, `hClk` becomes 1 in the tick equal to the rise location and becomes 0 in the tick equal to the fall location. Between those ticks it keeps its level. Tick numbers count from the tick in which `pixStart` is high.
- R5: `hClkN` is the logical inverse of `hClk` in every clock cycle.
- R6: The inputs `riseCode`, `fallCode` and `phaseSel` are sampled only in tick 47 and govern the period that follows. Changing them at any other tick has no effect on the outputs.
- R7: When the active rise and fall locations are equal, `hClk` produces no edge during that period and holds its level.
- R8: `phaseSel` is a plain binary tick number from 0 to 47. `dataOut` changes only in the tick equal to the active phase, so a phase of 0 aligns the data change with the start of the period.
- R9: The value on `sampleIn` during tick 47 is the sample of the period that starts next, call it P. It is driven on `dataOut` from the phase tick of period P+11.
- R10: After reset, the counter is at tick 0 and `hClk` is 1, `hClkN` is 0, `dataOut` is 0 and `codeErr` is 0. The active settings are rise location 0, fall location 24 and phase 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Tick clock, 48 ticks per pixel period |
| rstN | input | 1 | Synchronous reset, active low |
| riseCode | input | 6 | Quadrant code for the `hClk` rising edge |
| fallCode | input | 6 | Quadrant code for the `hClk` falling edge |
| phaseSel | input | 6 | Tick at which `dataOut` is updated, binary 0 to 47 |
| sampleIn | input | DATA_W | Pixel sample stream, taken once per period |
| hClk | output | 1 | Primary horizontal clock |
| hClkN | output | 1 | Inverse of `hClk` |
| pixStart | output | 1 | High during tick 0 of each period |
| dataOut | output | DATA_W | Delayed and retimed sample |
| codeErr | output | 1 | A value was rejected at the start of this period |

## Verification
The first pattern sweeps the rising-edge code through all 48 legal values, with the falling edge half a period away. This separates a decoder that misplaces one quadrant or step from a correct one, and shows an off-by-one tick as a shifted edge. Random legal codes and phases are then changed at random ticks inside periods. Those changes show whether a setting leaks into the period already running, and whether the data stream comes out exactly eleven periods late at the selected tick. Further patterns use illegal step fields and phases, equal rise and fall codes, and the phase extremes 0 and 47. These show apart a design that holds the old setting from one that loads garbage, and one that holds the level from one that toggles or forces it. They also show whether data retiming at the period boundary reads the right pipeline stage.

// File: rtl/subpix_edge_pkg.sv
package subpix_edge_pkg;

  localparam int QUADS          = 4;
  localparam int STEPS_PER_QUAD = 12;
  localparam int TICKS          = QUADS * STEPS_PER_QUAD;
  localparam int CODE_W         = 6;
  localparam int STEP_W         = CODE_W - 2;
  localparam int TICK_W         = $clog2(TICKS);

  typedef logic [TICK_W-1:0] tick_t;
  typedef logic [CODE_W-1:0] code_t;

  // strobes from control to datapath, all referring to the tick being entered
  typedef struct packed {
    logic periodWrap;
    logic riseHit;
    logic fallHit;
    logic dataHit;
  } edge_strobe_t;

  localparam tick_t RISE_RESET  = tick_t'(0);
  localparam tick_t FALL_RESET  = tick_t'(TICKS / 2);
  localparam tick_t PHASE_RESET = tick_t'(0);

endpackage

// File: rtl/subpix_code_dec.sv
module subpix_code_dec
  import subpix_edge_pkg::*;
(
  input  code_t code,
  output tick_t loc,
  output logic  legal
);

  localparam logic [STEP_W-1:0] STEP_LIMIT = STEP_W'(STEPS_PER_QUAD);

  logic [1:0]        quad;
  logic [STEP_W-1:0] step;

  always_comb begin
    quad  = code[CODE_W-1 -: 2];
    step  = code[STEP_W-1:0];
    legal = step < STEP_LIMIT;
    loc   = tick_t'(quad) * tick_t'(STEPS_PER_QUAD) + tick_t'(step);
  end

endmodule

// File: rtl/subpix_edge_ctrl.sv
module subpix_edge_ctrl
  import subpix_edge_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  code_t        riseCode,
  input  code_t        fallCode,
  input  tick_t        phaseSel,
  output edge_strobe_t strobe,
  output logic         pixStart,
  output logic         codeErr
);

  localparam int    NUM_EDGES = 2;
  localparam tick_t LAST_TICK = tick_t'(TICKS - 1);

  tick_t tickCnt, tickNext;
  logic  wrap;

  tick_t riseAct, fallAct, phaseAct;
  tick_t riseNew, fallNew, phaseNew;
  tick_t riseSel, fallSel, phaseSelAct;
  logic  errReg;
  logic  phaseLegal;

  code_t              codeArr  [NUM_EDGES];
  tick_t              locArr   [NUM_EDGES];
  logic [NUM_EDGES-1:0] legalVec;

  assign codeArr[0] = riseCode;
  assign codeArr[1] = fallCode;

  for (genvar g = 0; g < NUM_EDGES; g++) begin : g_dec
    subpix_code_dec u_dec (
      .code  (codeArr[g]),
      .loc   (locArr[g]),
      .legal (legalVec[g])
    );
  end

  always_comb begin
    wrap       = (tickCnt == LAST_TICK);
    tickNext   = wrap ? '0 : tickCnt + tick_t'(1);
    phaseLegal = phaseSel < tick_t'(TICKS);
    riseNew    = legalVec[0] ? locArr[0] : riseAct;
    fallNew    = legalVec[1] ? locArr[1] : fallAct;
    phaseNew   = phaseLegal  ? phaseSel  : phaseAct;
    riseSel     = wrap ? riseNew  : riseAct;
    fallSel     = wrap ? fallNew  : fallAct;
    phaseSelAct = wrap ? phaseNew : phaseAct;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tickCnt  <= '0;
      riseAct  <= RISE_RESET;
      fallAct  <= FALL_RESET;
      phaseAct <= PHASE_RESET;
      errReg   <= 1'b0;
    end else begin
      tickCnt <= tickNext;
      if (wrap) begin
        riseAct  <= riseNew;
        fallAct  <= fallNew;
        phaseAct <= phaseNew;
        errReg   <= !(&legalVec) || !phaseLegal;
      end
    end
  end

  always_comb begin
    strobe.periodWrap = wrap;
    strobe.riseHit    = (tickNext == riseSel);
    strobe.fallHit    = (tickNext == fallSel);
    strobe.dataHit    = (tickNext == phaseSelAct);
  end

  assign pixStart = (tickCnt == '0);
  assign codeErr  = errReg;

  // R1
  tick_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    tickCnt < tick_t'(TICKS));

  // R1
  tick_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    !wrap |=> tickCnt == $past(tickCnt) + tick_t'(1));

  // R6
  mid_period_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !wrap |=> ($stable(riseAct) && $stable(fallAct) && $stable(phaseAct)));

  // R3
  legal_loc_chk: assert property (@(posedge clk) disable iff (!rstN)
    riseAct < tick_t'(TICKS) && fallAct < tick_t'(TICKS) && phaseAct < tick_t'(TICKS));

endmodule

// File: rtl/subpix_edge_dp.sv
module subpix_edge_dp
  import subpix_edge_pkg::*;
#(
  parameter int DATA_W  = 10,
  parameter int LATENCY = 11
) (
  input  logic              clk,
  input  logic              rstN,
  input  edge_strobe_t      strobe,
  input  logic [DATA_W-1:0] sampleIn,
  output logic              hClk,
  output logic              hClkN,
  output logic [DATA_W-1:0] dataOut
);

  localparam int STAGES = LATENCY + 1;

  logic [DATA_W-1:0] pipe [STAGES];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pipe[0] <= '0;
    end else if (strobe.periodWrap) begin
      pipe[0] <= sampleIn;
    end
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rstN) begin
        pipe[s] <= '0;
      end else if (strobe.periodWrap) begin
        pipe[s] <= pipe[s-1];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dataOut <= '0;
    end else if (strobe.dataHit) begin
      dataOut <= strobe.periodWrap ? pipe[STAGES-2] : pipe[STAGES-1];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hClk <= 1'b1;
    end else if (strobe.riseHit && !strobe.fallHit) begin
      hClk <= 1'b1;
    end else if (strobe.fallHit && !strobe.riseHit) begin
      hClk <= 1'b0;
    end
  end

  assign hClkN = ~hClk;

  // R4
  rise_edge_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.riseHit && !strobe.fallHit) |=> hClk);

  // R4
  fall_edge_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.fallHit && !strobe.riseHit) |=> !hClk);

  // R7
  equal_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.riseHit && strobe.fallHit) |=> $stable(hClk));

  // R8
  data_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.dataHit |=> $stable(dataOut));

endmodule

// File: rtl/subpix_edge_gen.sv
module subpix_edge_gen
  import subpix_edge_pkg::*;
#(
  parameter int DATA_W  = 10,
  parameter int LATENCY = 11
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [5:0]        riseCode,
  input  logic [5:0]        fallCode,
  input  logic [5:0]        phaseSel,
  input  logic [DATA_W-1:0] sampleIn,
  output logic              hClk,
  output logic              hClkN,
  output logic              pixStart,
  output logic [DATA_W-1:0] dataOut,
  output logic              codeErr
);

  edge_strobe_t strobe;

  subpix_edge_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .riseCode (riseCode),
    .fallCode (fallCode),
    .phaseSel (phaseSel),
    .strobe   (strobe),
    .pixStart (pixStart),
    .codeErr  (codeErr)
  );

  subpix_edge_dp #(
    .DATA_W  (DATA_W),
    .LATENCY (LATENCY)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .sampleIn (sampleIn),
    .hClk     (hClk),
    .hClkN    (hClkN),
    .dataOut  (dataOut)
  );

endmodule

// File: tb/subpix_edge_gen_tb.sv
module subpix_edge_gen_tb;

  localparam int DATA_W  = 10;
  localparam int LATENCY = 11;
  localparam int TICKS   = 48;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [5:0]        riseCode = 6'd0;
  logic [5:0]        fallCode = 6'd32;
  logic [5:0]        phaseSel = 6'd0;
  logic [DATA_W-1:0] sampleIn = '0;
  logic              hClk, hClkN, pixStart, codeErr;
  logic [DATA_W-1:0] dataOut;

  always #10 clk = ~clk;

  subpix_edge_gen #(.DATA_W(DATA_W), .LATENCY(LATENCY)) u_dut (
    .clk(clk), .rstN(rstN), .riseCode(riseCode), .fallCode(fallCode),
    .phaseSel(phaseSel), .sampleIn(sampleIn), .hClk(hClk), .hClkN(hClkN),
    .pixStart(pixStart), .dataOut(dataOut), .codeErr(codeErr)
  );

  int checks = 0;
  int fails  = 0;
  bit checking = 0;
  bit randData = 0;
  bit finished = 0;
  string edgeTag = "R4";
  string dataTag = "R9";

  // reference state
  int mTick, mRise, mFall, mPhase, mH, mErr;
  int mData;
  int mPipe [LATENCY+1];

  function automatic bit codeOk(input logic [5:0] c);
    return int'(c[3:0]) < 12;
  endfunction

  function automatic int codeLoc(input logic [5:0] c);
    return int'(c[5:4]) * 12 + int'(c[3:0]);
  endfunction

  function automatic logic [5:0] locCode(input int loc);
    logic [5:0] c;
    c[5:4] = 2'(loc / 12);
    c[3:0] = 4'(loc % 12);
    return c;
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (!rstN) begin
      mTick = 0; mRise = 0; mFall = 24; mPhase = 0; mH = 1; mErr = 0; mData = 0;
      for (int i = 0; i <= LATENCY; i++) mPipe[i] = 0;
    end else begin
      int nt;
      nt = (mTick == TICKS-1) ? 0 : mTick + 1;
      if (nt == 0) begin
        mErr = 0;
        if (codeOk(riseCode)) mRise = codeLoc(riseCode); else mErr = 1;
        if (codeOk(fallCode)) mFall = codeLoc(fallCode); else mErr = 1;
        if (int'(phaseSel) < TICKS) mPhase = int'(phaseSel); else mErr = 1;
        for (int i = LATENCY; i >= 1; i--) mPipe[i] = mPipe[i-1];
        mPipe[0] = int'(sampleIn);
      end
      if (mRise != mFall) begin
        if (nt == mRise) mH = 1;
        else if (nt == mFall) mH = 0;
      end
      if (nt == mPhase) mData = mPipe[LATENCY];
      mTick = nt;
    end
  end

  always @(negedge clk) begin
    if (checking && !finished) begin
      check(pixStart == (mTick == 0), "R1", "pixStart", int'(pixStart), int'(mTick == 0));
      check(int'(hClk) == mH, (mRise == mFall) ? "R7" : edgeTag, "hClk", int'(hClk), mH);
      check(hClkN == ~hClk, "R5", "hClkN", int'(hClkN), int'(~hClk));
      check(int'(dataOut) == mData, dataTag, "dataOut", int'(dataOut), mData);
      check(int'(codeErr) == mErr, "R3", "codeErr", int'(codeErr), mErr);
    end
    if (randData) sampleIn <= DATA_W'($urandom);
  end

  task automatic waitTicks(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [5:0] randLegal();
    logic [5:0] c;
    c[5:4] = 2'($urandom % 4);
    c[3:0] = 4'($urandom % 12);
    return c;
  endfunction

  function automatic logic [5:0] randIllegal();
    logic [5:0] c;
    c[5:4] = 2'($urandom % 4);
    c[3:0] = 4'(12 + $urandom % 4);
    return c;
  endfunction

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run hung actual=%0d expected=%0d", checks, 0);
    summary();
  end

  initial begin
    void'($urandom(32'h5EED));
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    // R10 reset state, before the first active edge
    check(hClk == 1'b1, "R10", "hClk after reset", int'(hClk), 1);
    check(hClkN == 1'b0, "R10", "hClkN after reset", int'(hClkN), 0);
    check(pixStart == 1'b1, "R10", "pixStart after reset", int'(pixStart), 1);
    check(dataOut == '0, "R10", "dataOut after reset", int'(dataOut), 0);
    check(codeErr == 1'b0, "R10", "codeErr after reset", int'(codeErr), 0);
    checking = 1;
    randData = 1;
    waitTicks(2 * TICKS);

    // R2 sweep of every legal location, fall half a period away
    edgeTag = "R2";
    for (int loc = 0; loc < TICKS; loc++) begin
      riseCode = locCode(loc);
      fallCode = locCode((loc + 24) % TICKS);
      waitTicks(2 * TICKS);
    end

    // R6 codes and phase changed at random ticks inside periods
    edgeTag = "R6";
    for (int p = 0; p < 150; p++) begin
      int cut;
      cut = int'($urandom % TICKS);
      waitTicks(cut);
      riseCode = randLegal();
      fallCode = randLegal();
      phaseSel = 6'($urandom % TICKS);
      waitTicks(TICKS - cut);
    end

    // R3 illegal steps and out-of-range phase
    edgeTag = "R4";
    for (int p = 0; p < 30; p++) begin
      riseCode = ($urandom % 2) ? randIllegal() : randLegal();
      fallCode = ($urandom % 2) ? randIllegal() : randLegal();
      phaseSel = ($urandom % 3 == 0) ? 6'(48 + $urandom % 16) : 6'($urandom % TICKS);
      waitTicks(TICKS);
    end

    // R7 equal rise and fall, directed then random
    riseCode = locCode(10); fallCode = locCode(10);
    waitTicks(3 * TICKS);
    riseCode = locCode(5); fallCode = locCode(30);
    waitTicks(2 * TICKS);
    for (int p = 0; p < 10; p++) begin
      riseCode = randLegal();
      fallCode = riseCode;
      waitTicks(2 * TICKS);
    end

    // R8 phase extremes, R9 latency with a fixed edge setup
    riseCode = locCode(0); fallCode = locCode(47);
    dataTag = "R8";
    phaseSel = 6'd0;
    waitTicks(14 * TICKS);
    phaseSel = 6'd47;
    waitTicks(14 * TICKS);
    dataTag = "R9";
    phaseSel = 6'd23;
    waitTicks(14 * TICKS);

    summary();
  end

endmodule